// File: doc/BRIEF.md
# Two-Stage Solenoid Strike Sequencer

This block times the strike of a solenoid-driven hammer. A note-on starts a full-power strike on the attack output. Later, the block raises an enable that starts a separate PWM hold generator, and it drops the attack output. The strike length and the hold delay are each given as a 16-bit tick count, split into a coarse byte and a fine byte. A 3-bit code picks how many system clocks make one tick.

The two deadlines are merged into two stages that run one after the other, so only one stage timer is needed. When the strike is longer than the hold delay, the hold enable comes up first and the attack drops at the end of stage two. Otherwise the attack drops first and the hold enable follows.

Each stage counts whole periods of 256 ticks, then counts its fine remainder. A 2-bit state word reports the attack and hold flags. A note-off at any time silences both outputs.

Top module: `strike_sequencer`

## Requirements
- R1: After reset, `attack_o` and `hold_en_o` are 0 and `state_o` is 2'b00.
- R2: A note-on accepted at a clock edge sets `attack_o`=1, `hold_en_o`=0 and `state_o`=2'b01 from that edge. In `state_o`, bit 0 is the attack flag and bit 1 is the hold flag.
- R3: The strike count is A = `atk_coarse`·256 + `atk_fine` and the delay count is D = `dly_coarse`·256 + `dly_fine`. A stage of count n lasts (n>>8)·256 ticks of coarse phase plus max(n & 255, 1) ticks of fine phase. A zero fine part therefore ends one tick after the coarse phase.
- R4: If A > D, stage 1 has count A−D and stage 2 has count D. `hold_en_o` rises when stage 1 ends and `attack_o` falls when stage 2 ends.
- R5: If A ≤ D, stage 1 has count A and stage 2 has count D−A. `attack_o` falls when stage 1 ends and `hold_en_o` rises when stage 2 ends.
- R6: `tick_sel` is sampled at note-on. Codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. An event due at tick T takes effect at the clock edge T·divider edges after the note-on edge. Later changes to `tick_sel` have no effect on the running note.
- R7: Codes 0, 6 and 7 produce no ticks. The attack stays high and the hold stays low until note-off.
- R8: A note-off clears `attack_o`, `hold_en_o` and `state_o` at the next edge and stops the timer. It wins over a note-on in the same cycle.
- R9: A note-on while a note is running restarts the sequence from stage 1, using the counts and code present at that edge.
- R10: After both stages end, `attack_o` stays 0 and `hold_en_o` stays 1 (`state_o`=2'b10) until note-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| note_on | input | 1 | One-cycle request to start a strike |
| note_off | input | 1 | One-cycle request to silence the note |
| atk_coarse | input | 8 | Strike length, 256-tick units |
| atk_fine | input | 8 | Strike length, single ticks |
| dly_coarse | input | 8 | Hold delay, 256-tick units |
| dly_fine | input | 8 | Hold delay, single ticks |
| tick_sel | input | 3 | Clock-to-tick divider code |
| attack_o | output | 1 | Full-power strike drive |
| hold_en_o | output | 1 | Enable for the PWM hold generator |
| state_o | output | 2 | Flags: bit 0 attack, bit 1 hold |

## Verification
- Note-on and note-off take effect at the first clock edge after they are sampled, so the bench reads the outputs on the falling edge right after that edge.
- The attack release and the hold start are due at edges T·divider after the note-on edge. T comes from the stage formula in R3–R5.
- The bench counts falling edges from the note-on edge and records the first cycle where each output changes. It compares that count with the exact figure it computes itself, so an event one cycle early or late is reported.
- The bench waits at least one full due time before it declares that an output never moved.

// File: rtl/strike_seq_pkg.sv
// Package: shared widths and types for the strike sequencer.
// Assumes tick counts are carried as a coarse byte and a fine byte.
package strike_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int SPAN_W = 2 * BYTE_W;

    // One tick count: whole coarse periods plus a fine remainder.
    typedef struct packed {
        logic [BYTE_W-1:0] coarse;
        logic [BYTE_W-1:0] fine;
    } span_t;

    // Sequencer phase.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_STG1 = 2'd1,
        SEQ_STG2 = 2'd2
    } seq_state_e;

endpackage

// File: rtl/strike_tick_gen.sv
// Tick generator: divides the system clock by a ratio chosen from a 3-bit code.
// The code is captured on restart. Unknown codes stop ticking altogether.
// Assumes restart comes with every note-on, so each note starts on a fresh phase.
module strike_tick_gen #(
    parameter int PRESC_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] code_i,
    output logic       tick_o
);

    logic [PRESC_W-1:0] cnt_q;
    logic [PRESC_W-1:0] lim_q;
    logic               valid_q;

    // Terminal count (divider minus one) for each supported code.
    function automatic logic [PRESC_W-1:0] lim_of(input logic [2:0] c);
        case (c)
            3'd1:    lim_of = PRESC_W'(0);
            3'd2:    lim_of = PRESC_W'(7);
            3'd3:    lim_of = PRESC_W'(63);
            3'd4:    lim_of = PRESC_W'(255);
            3'd5:    lim_of = PRESC_W'(1023);
            default: lim_of = PRESC_W'(0);
        endcase
    endfunction

    assign tick_o = valid_q && (cnt_q == lim_q);

    // Capture the code on restart, otherwise advance the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            lim_q   <= '0;
            valid_q <= 1'b0;
        end else if (restart) begin
            cnt_q   <= '0;
            lim_q   <= lim_of(code_i);
            valid_q <= (code_i >= 3'd1) && (code_i <= 3'd5);
        end else if (tick_o) begin
            cnt_q   <= '0;
        end else if (valid_q) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart && lim_q != '0) |=> !tick_o); // R6

endmodule

// File: rtl/strike_stage_plan.sv
// Stage planner: turns the strike and delay counts into two back-to-back stages.
// Purely combinational. The longer deadline always lands at the end of stage two.
module strike_stage_plan
    import strike_seq_pkg::*;
(
    input  span_t atk_i,
    input  span_t dly_i,
    output span_t stg1_o,
    output span_t stg2_o,
    output logic  hold_first_o
);

    logic [SPAN_W-1:0] atk_n;
    logic [SPAN_W-1:0] dly_n;

    assign atk_n = {atk_i.coarse, atk_i.fine};
    assign dly_n = {dly_i.coarse, dly_i.fine};

    // Order the two deadlines and split them into stage lengths.
    always_comb begin
        hold_first_o = (atk_n > dly_n);
        if (hold_first_o) begin
            stg1_o = span_t'(atk_n - dly_n);
            stg2_o = span_t'(dly_n);
        end else begin
            stg1_o = span_t'(atk_n);
            stg2_o = span_t'(dly_n - atk_n);
        end
    end

endmodule

// File: rtl/strike_stage_timer.sv
// Stage timer: counts whole coarse periods of 2**BYTE_W ticks, then the fine remainder.
// A zero fine part still takes one tick. done_o is a one-cycle pulse on the final tick.
// Assumes the owner reloads it, or drops en, on the cycle done_o is high.
module strike_stage_timer
    import strike_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  load,
    input  span_t load_val,
    input  logic  tick,
    output logic  done_o
);

    logic [BYTE_W-1:0] coarse_q;
    logic [BYTE_W-1:0] sub_q;
    logic [BYTE_W-1:0] fine_q;
    logic              in_coarse;

    assign in_coarse = (coarse_q != '0);
    assign done_o    = en && tick && !in_coarse && (fine_q <= BYTE_W'(1));

    // Load a new stage, or consume one tick of the current stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            sub_q    <= '0;
            fine_q   <= '0;
        end else if (load) begin
            coarse_q <= load_val.coarse;
            fine_q   <= load_val.fine;
            sub_q    <= '0;
        end else if (en && tick) begin
            if (in_coarse) begin
                if (&sub_q) begin
                    sub_q    <= '0;
                    coarse_q <= coarse_q - 1'b1;
                end else begin
                    sub_q    <= sub_q + 1'b1;
                end
            end else if (fine_q > BYTE_W'(1)) begin
                fine_q <= fine_q - 1'b1;
            end
        end
    end

    AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !load && !in_coarse && fine_q > BYTE_W'(1))
        |=> (fine_q == $past(fine_q) - BYTE_W'(1))); // R3

    AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !load && in_coarse && (&sub_q))
        |=> (coarse_q == $past(coarse_q) - BYTE_W'(1) && sub_q == '0)); // R3

endmodule

// File: rtl/strike_sequencer.sv
// Strike sequencer top: a note-on drives the attack output high and starts stage one.
// The ends of the two stages release attack and enable hold, in an order set by the planner.
// A note-off silences everything and takes priority over a note-on in the same cycle.
module strike_sequencer
    import strike_seq_pkg::*;
#(
    parameter int PRESC_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       note_on,
    input  logic       note_off,
    input  logic [7:0] atk_coarse,
    input  logic [7:0] atk_fine,
    input  logic [7:0] dly_coarse,
    input  logic [7:0] dly_fine,
    input  logic [2:0] tick_sel,
    output logic       attack_o,
    output logic       hold_en_o,
    output logic [1:0] state_o
);

    seq_state_e state_q;
    logic       attack_q;
    logic       hold_q;
    span_t      stg2_q;
    logic       hold_first_q;

    span_t      stg1_w;
    span_t      stg2_w;
    logic       hold_first_w;
    logic       tick_w;
    logic       done_w;
    logic       start_w;
    logic       adv_w;
    logic       tmr_load;
    span_t      tmr_val;

    assign start_w  = note_on && !note_off;
    assign adv_w    = done_w && (state_q == SEQ_STG1) && !note_on && !note_off;
    assign tmr_load = start_w || adv_w;
    assign tmr_val  = start_w ? stg1_w : stg2_q;

    strike_stage_plan u_plan (
        .atk_i        ({atk_coarse, atk_fine}),
        .dly_i        ({dly_coarse, dly_fine}),
        .stg1_o       (stg1_w),
        .stg2_o       (stg2_w),
        .hold_first_o (hold_first_w)
    );

    strike_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (note_on),
        .code_i  (tick_sel),
        .tick_o  (tick_w)
    );

    strike_stage_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state_q != SEQ_IDLE),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick_w),
        .done_o   (done_w)
    );

    // Phase and output register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SEQ_IDLE;
            attack_q     <= 1'b0;
            hold_q       <= 1'b0;
            stg2_q       <= '0;
            hold_first_q <= 1'b0;
        end else if (note_off) begin
            state_q  <= SEQ_IDLE;
            attack_q <= 1'b0;
            hold_q   <= 1'b0;
        end else if (note_on) begin
            state_q      <= SEQ_STG1;
            attack_q     <= 1'b1;
            hold_q       <= 1'b0;
            stg2_q       <= stg2_w;
            hold_first_q <= hold_first_w;
        end else if (done_w) begin
            case (state_q)
                SEQ_STG1: begin
                    state_q <= SEQ_STG2;
                    if (hold_first_q) hold_q   <= 1'b1;
                    else              attack_q <= 1'b0;
                end
                SEQ_STG2: begin
                    state_q <= SEQ_IDLE;
                    if (hold_first_q) attack_q <= 1'b0;
                    else              hold_q   <= 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign attack_o  = attack_q;
    assign hold_en_o = hold_q;
    assign state_o   = {hold_q, attack_q};

    AST_OFF_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        note_off |=> (!attack_o && !hold_en_o)); // R8

    AST_ON_STRIKES: assert property (@(posedge clk) disable iff (!rst_n)
        (note_on && !note_off) |=> (attack_o && !hold_en_o)); // R2

    AST_ATK_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(attack_o) |-> ($past(note_off) || $past(done_w))); // R5

    AST_HOLD_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_en_o) |-> ($past(done_w) && !$past(note_off) && !$past(note_on))); // R4

endmodule

// File: tb/tb_strike_sequencer.sv
`timescale 1ns/1ps
module tb_strike_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       note_on = 1'b0;
    logic       note_off = 1'b0;
    logic [7:0] atk_coarse = '0;
    logic [7:0] atk_fine = '0;
    logic [7:0] dly_coarse = '0;
    logic [7:0] dly_fine = '0;
    logic [2:0] tick_sel = 3'd1;
    logic       attack_o;
    logic       hold_en_o;
    logic [1:0] state_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    strike_sequencer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .note_on    (note_on),
        .note_off   (note_off),
        .atk_coarse (atk_coarse),
        .atk_fine   (atk_fine),
        .dly_coarse (dly_coarse),
        .dly_fine   (dly_fine),
        .tick_sel   (tick_sel),
        .attack_o   (attack_o),
        .hold_en_o  (hold_en_o),
        .state_o    (state_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Ticks a stage of count n lasts (R3).
    function automatic int dur(input int n);
        return n + (((n % 256) == 0) ? 1 : 0);
    endfunction

    function automatic int divr(input int code);
        case (code)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    // Pulse note-on, change tick_sel afterwards (R6 latch), check the strike state (R2).
    task automatic start_note(input int a, input int d, input int code);
        @(negedge clk);
        atk_coarse = 8'(a / 256); atk_fine = 8'(a % 256);
        dly_coarse = 8'(d / 256); dly_fine = 8'(d % 256);
        tick_sel = 3'(code);
        note_on = 1'b1;
        @(posedge clk);
        @(negedge clk);
        note_on = 1'b0;
        tick_sel = (code == 1) ? 3'd5 : 3'd1;
        check(attack_o == 1'b1 && hold_en_o == 1'b0 && state_o == 2'b01,
              "R2 strike on note-on", int'(state_o), 1);
    endtask

    task automatic stop_note();
        @(negedge clk);
        note_off = 1'b1;
        @(posedge clk);
        @(negedge clk);
        note_off = 1'b0;
        check(attack_o == 1'b0 && hold_en_o == 1'b0 && state_o == 2'b00,
              "R8 note-off clears", int'({hold_en_o, attack_o}), 0);
    endtask

    // Measure when attack falls and hold rises, relative to the note-on edge.
    task automatic measure(input int a, input int d, input int code);
        int dv = divr(code);
        int t_att, t_hold, lim, seen_att, seen_hold;
        if (a > d) begin
            t_hold = dur(a - d);
            t_att  = t_hold + dur(d);
        end else begin
            t_att  = dur(a);
            t_hold = t_att + dur(d - a);
        end
        t_att  = t_att * dv;
        t_hold = t_hold * dv;
        lim = ((t_att > t_hold) ? t_att : t_hold) + 3;
        seen_att = -1;
        seen_hold = -1;
        for (int c = 1; c <= lim; c++) begin
            @(negedge clk);
            if (seen_att < 0 && !attack_o) seen_att = c;
            if (seen_hold < 0 && hold_en_o) seen_hold = c;
        end
        if (a > d) begin
            check(seen_hold == t_hold, "R4/R3 hold start", seen_hold, t_hold);
            check(seen_att == t_att, "R4/R3 attack release", seen_att, t_att);
        end else begin
            check(seen_att == t_att, "R5/R3 attack release", seen_att, t_att);
            check(seen_hold == t_hold, "R5/R3 hold start", seen_hold, t_hold);
        end
        check(state_o == 2'b10, "R10 idle holding", int'(state_o), 2);
        if (code != 1) check(seen_att == t_att, "R6 divider timing", seen_att, t_att);
    endtask

    task automatic full_note(input int a, input int d, input int code);
        start_note(a, d, code);
        measure(a, d, code);
        stop_note();
    endtask

    initial begin
        int vals[8] = '{0, 1, 2, 5, 255, 256, 257, 300};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(attack_o == 1'b0 && hold_en_o == 1'b0 && state_o == 2'b00,
              "R1 reset state", int'(state_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(state_o == 2'b00, "R1 after reset release", int'(state_o), 0);

        // Sweep of both orderings with coarse and fine corners at divider 1.
        foreach (vals[i]) foreach (vals[j]) full_note(vals[i], vals[j], 1);

        // Other divider codes (R6).
        full_note(3, 5, 2);
        full_note(5, 3, 2);
        full_note(2, 1, 3);
        full_note(1, 0, 4);
        full_note(0, 1, 5);

        // Retrigger during stage 1 (R9).
        start_note(40, 80, 1);
        repeat (5) @(negedge clk);
        start_note(3, 1, 1);
        measure(3, 1, 1);
        stop_note();
        // Retrigger while holding (R9).
        start_note(1, 2, 1);
        repeat (6) @(negedge clk);
        start_note(6, 2, 2);
        measure(6, 2, 2);
        stop_note();

        // Note-off mid-sequence stops the timer (R8).
        start_note(100, 50, 1);
        repeat (20) @(negedge clk);
        stop_note();
        repeat (200) @(negedge clk);
        check(attack_o == 1'b0 && hold_en_o == 1'b0, "R8 stays silent", int'(state_o), 0);

        // Note-off wins over a simultaneous note-on (R8).
        @(negedge clk);
        note_on = 1'b1; note_off = 1'b1; tick_sel = 3'd1;
        @(posedge clk);
        @(negedge clk);
        note_on = 1'b0; note_off = 1'b0;
        check(state_o == 2'b00, "R8 off beats on", int'(state_o), 0);

        // Unsupported codes give no ticks (R7).
        for (int k = 0; k < 3; k++) begin
            int cd = (k == 0) ? 0 : 5 + k;
            start_note(1, 1, cd);
            repeat (1500) @(negedge clk);
            check(attack_o == 1'b1 && hold_en_o == 1'b0, "R7 no ticks for bad code",
                  int'(state_o), 1);
            stop_note();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule